// File: doc/BRIEF.md
# Configurable Test Pattern Generator

This block sits at the tail of a sample data path. It can replace the normal data stream with a synthetic 20-bit pattern. The available patterns are two ramps, a static word and two alternating patterns. All of them take their value from a 20-bit custom word. A 3-bit mode selects the pattern. A select bit decides whether the pattern advances on the sample-rate strobe or on the decimated-rate strobe. Each generated value is formatted for 16-bit or 32-bit output resolution and placed in a registered 32-bit output word.

When the generator is off, words from the normal data input pass through the same output register. Both data edges use valid/ready. The output holds its word and its valid flag until `out_ready` is seen high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While a pattern mode is active, accepted input words are discarded. A pattern strobe that arrives while the output is stalled is dropped, and the pattern does not advance for it. A strobe is a single-cycle pulse and is never queued.

Top module: `tpat_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `out_valid` is 0 and `out_data` is 0; the ramp value and the alternation phase start cleared.
- R2: With mode 000, an input word accepted in cycle N (`in_valid` and `in_ready` both high) appears unchanged on all 32 bits of `out_data`, with `out_valid` high, after the clock edge ending cycle N; pattern strobes have no effect.
- R3: Modes 011 and 111 behave exactly like mode 000.
- R4: Mode 001 emits a ramp that starts at 0 and grows by 1 per emitted word, wrapping modulo 2^20.
- R5: Mode 010 emits a ramp that starts at 0 and grows by the custom word per emitted word, wrapping modulo 2^20.
- R6: Mode 100 emits the custom word on every emitted word.
- R7: Mode 101 emits the custom word, then its bitwise inverse, alternating on every emitted word. Mode 110 alternates in the same way between the custom word and zero. Both start with the custom word.
- R8: With `res32` = 1, the 20-bit pattern value occupies `out_data[31:12]` and bits 11:0 are zero. With `res32` = 0, `out_data[15:0]` carries pattern bits 19:4 and bits 31:16 are zero.
- R9: With `adv_sel` = 0, a pattern word is emitted on `smp_stb` and `dec_stb` is ignored. With `adv_sel` = 1, the roles of the two strobes are reversed.
- R10: Any change of `mode` restarts the ramp at 0 and the alternation on the custom word, whether or not a word is emitted in the cycle of the change.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold. A strobe during the stall emits nothing and does not advance the pattern. `in_ready` equals `!out_valid || out_ready`.
- R12: When the held word is accepted and no new word is loaded in the same cycle, `out_valid` falls after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_sel | input | 1 | 0: advance on sample strobe, 1: advance on decimated strobe |
| smp_stb | input | 1 | Sample-rate advance strobe |
| dec_stb | input | 1 | Decimated-rate advance strobe |
| mode | input | 3 | Pattern mode |
| custom | input | 20 | Custom pattern word |
| res32 | input | 1 | 1: 32-bit output format, 0: 16-bit output format |
| in_valid | input | 1 | Normal data valid |
| in_ready | output | 1 | Normal data accepted this cycle |
| in_data | input | 32 | Normal data word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_data | output | 32 | Output word |

## Verification
The bench drives the strongest ramp step so that the accumulator wraps. A design that saturates or carries out of bit 19 would return 0x180000 truncated wrongly instead of 0x80000. It reads the word after each restart and at odd and even beat counts of both alternating modes. A phase that is not cleared on a mode change, or an alternation that starts on the inverse, shows up as a swapped value. It stalls the output while strobes keep arriving. A design that advanced the ramp on dropped strobes would skip values once the stall ends, and a design that lost the held word would change `out_data` during the stall. It also pulses the strobe that is not selected. A design with the select inverted would emit a word there. It checks both resolutions on the same values, so padding on the wrong side or the wrong truncated slice is caught.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

  typedef enum logic [2:0] {
    TP_OFF       = 3'b000,
    TP_RAMP_UNIT = 3'b001,
    TP_RAMP_STEP = 3'b010,
    TP_RSV_A     = 3'b011,
    TP_STATIC    = 3'b100,
    TP_TGL_INV   = 3'b101,
    TP_TGL_ZERO  = 3'b110,
    TP_RSV_B     = 3'b111
  } tp_mode_e;

  // True for the modes that replace the normal data stream.
  function automatic logic tp_is_pattern(input logic [2:0] m);
    case (m)
      TP_RAMP_UNIT, TP_RAMP_STEP, TP_STATIC, TP_TGL_INV, TP_TGL_ZERO: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tpat_core.sv
module tpat_core
  import tpat_pkg::*;
#(
  parameter int PAT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic [PAT_W-1:0] custom,
  input  logic             emit,
  output logic             pat_on,
  output logic [PAT_W-1:0] pat_val
);

  logic [2:0]       mode_q;
  logic [PAT_W-1:0] acc;
  logic             ph;
  logic             restart;
  logic [PAT_W-1:0] acc_eff;
  logic             ph_eff;
  logic [PAT_W-1:0] step;

  assign restart = (mode != mode_q);
  assign acc_eff = restart ? '0 : acc;
  assign ph_eff  = restart ? 1'b0 : ph;
  assign pat_on  = tp_is_pattern(mode);
  assign step    = (mode == TP_RAMP_UNIT) ? PAT_W'(1) : custom;

  always_comb begin
    case (mode)
      TP_RAMP_UNIT, TP_RAMP_STEP: pat_val = acc_eff;
      TP_STATIC:                  pat_val = custom;
      TP_TGL_INV:                 pat_val = ph_eff ? ~custom : custom;
      TP_TGL_ZERO:                pat_val = ph_eff ? '0 : custom;
      default:                    pat_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= TP_OFF;
      acc    <= '0;
      ph     <= 1'b0;
    end else begin
      mode_q <= mode;
      if (emit) begin
        acc <= acc_eff + step;
        ph  <= ~ph_eff;
      end else if (restart) begin
        acc <= '0;
        ph  <= 1'b0;
      end
    end
  end

  // R10
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !emit) |=> (acc == '0 && !ph));

  // R4
  ramp_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && mode == TP_RAMP_UNIT && !restart) |=> (acc == $past(acc) + PAT_W'(1)));

  // R7
  phase_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && restart) |=> ph);

endmodule

// File: rtl/tpat_fmt.sv
module tpat_fmt #(
  parameter int PAT_W    = 20,
  parameter int OUT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             res32,
  input  logic [PAT_W-1:0] pat,
  output logic [OUT_W-1:0] word
);

  localparam int PAD_W  = OUT_W - PAT_W;
  localparam int HIGH_W = OUT_W - NARROW_W;

  logic [OUT_W-1:0] wide;
  logic [OUT_W-1:0] narrow;

  assign wide   = {pat, {PAD_W{1'b0}}};
  assign narrow = {{HIGH_W{1'b0}}, pat[PAT_W-1 -: NARROW_W]};
  assign word   = res32 ? wide : narrow;

endmodule

// File: rtl/tpat_gen.sv
module tpat_gen
  import tpat_pkg::*;
#(
  parameter int PAT_W    = 20,
  parameter int OUT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_sel,
  input  logic             smp_stb,
  input  logic             dec_stb,
  input  logic [2:0]       mode,
  input  logic [PAT_W-1:0] custom,
  input  logic             res32,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OUT_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);

  logic             stb;
  logic             slot_free;
  logic             pat_on;
  logic             emit;
  logic             take_in;
  logic [PAT_W-1:0] pat_val;
  logic [OUT_W-1:0] pat_word;

  assign stb       = adv_sel ? dec_stb : smp_stb;
  assign slot_free = !out_valid || out_ready;
  assign in_ready  = slot_free;
  assign emit      = pat_on && stb && slot_free;
  assign take_in   = !pat_on && in_valid && slot_free;

  tpat_core #(.PAT_W(PAT_W)) core_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .custom  (custom),
    .emit    (emit),
    .pat_on  (pat_on),
    .pat_val (pat_val)
  );

  tpat_fmt #(.PAT_W(PAT_W), .OUT_W(OUT_W), .NARROW_W(NARROW_W)) fmt_i (
    .res32 (res32),
    .pat   (pat_val),
    .word  (pat_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (emit || take_in) begin
      out_valid <= 1'b1;
      out_data  <= emit ? pat_word : in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2
  pass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !tp_is_pattern(mode)) |=> (out_valid && out_data == $past(in_data)));

endmodule

// File: tb/tpat_gen_tb.sv
module tpat_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_sel = 1'b0;
  logic        smp_stb = 1'b0;
  logic        dec_stb = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic [19:0] custom = '0;
  logic        res32 = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tpat_gen dut_i (
    .clk(clk), .rst_n(rst_n), .adv_sel(adv_sel), .smp_stb(smp_stb),
    .dec_stb(dec_stb), .mode(mode), .custom(custom), .res32(res32),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // {mode, res32, custom, beat index, expected word}
  localparam int NV = 10;
  localparam logic [63:0] VEC [NV] = '{
    {3'd1, 1'b1, 20'h00000, 8'd3,  32'h0000_3000}, // R4 R8
    {3'd1, 1'b0, 20'h00000, 8'd32, 32'h0000_0002}, // R4 R8 narrow
    {3'd2, 1'b0, 20'h00010, 8'd5,  32'h0000_0005}, // R5
    {3'd2, 1'b1, 20'h80000, 8'd3,  32'h8000_0000}, // R5 wrap
    {3'd4, 1'b1, 20'hABCDE, 8'd7,  32'hABCD_E000}, // R6
    {3'd4, 1'b0, 20'hABCDE, 8'd0,  32'h0000_ABCD}, // R6 R8
    {3'd5, 1'b1, 20'h12345, 8'd1,  32'hEDCB_A000}, // R7 inverse
    {3'd5, 1'b1, 20'h12345, 8'd2,  32'h1234_5000}, // R7
    {3'd6, 1'b0, 20'hFFFFF, 8'd1,  32'h0000_0000}, // R7 zero
    {3'd6, 1'b0, 20'hFFFFF, 8'd4,  32'h0000_FFFF}  // R7
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Called just after a falling edge; pulses the sample strobe n times.
  task automatic run_beats(input int n, output logic [31:0] last);
    last = '0;
    for (int i = 0; i < n; i++) begin
      smp_stb = 1'b1;
      @(negedge clk);
      last = out_data;
    end
    smp_stb = 1'b0;
  endtask

  task automatic idle_mode();
    mode = 3'b000;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'b0, out_valid}, 32'h0);
    chk("R1 reset data", out_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {31'b0, out_valid}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      idle_mode();
      mode   = VEC[v][63:61];
      res32  = VEC[v][60];
      custom = VEC[v][59:40];
      run_beats(int'(VEC[v][39:32]) + 1, w);
      chk($sformatf("R4-table entry %0d (R5 R6 R7 R8)", v), w, VEC[v][31:0]);
    end

    // R2 pass-through, strobe ignored
    idle_mode();
    in_valid = 1'b1; in_data = 32'hDEAD_BEEF; smp_stb = 1'b1;
    @(negedge clk);
    chk("R2 pass data", out_data, 32'hDEAD_BEEF);
    chk("R2 pass valid", {31'b0, out_valid}, 32'h1);
    smp_stb = 1'b0;
    // R3 unused modes pass through
    mode = 3'b011; in_data = 32'h0123_4567;
    @(negedge clk);
    chk("R3 mode 011", out_data, 32'h0123_4567);
    mode = 3'b111; in_data = 32'h89AB_CDEF;
    @(negedge clk);
    chk("R3 mode 111", out_data, 32'h89AB_CDEF);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R12 valid drops", {31'b0, out_valid}, 32'h0);

    // R11 stall
    idle_mode();
    mode = 3'b001; res32 = 1'b1; out_ready = 1'b0;
    run_beats(1, w);
    chk("R11 first beat", w, 32'h0);
    chk("R11 in_ready low", {31'b0, in_ready}, 32'h0);
    run_beats(3, w);
    chk("R11 held data", w, 32'h0);
    chk("R11 held valid", {31'b0, out_valid}, 32'h1);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R12 drained", {31'b0, out_valid}, 32'h0);
    run_beats(1, w);
    chk("R11 no skip", w, 32'h0000_1000);
    run_beats(2, w);
    chk("R4 continue", w, 32'h0000_3000);

    // R10 mode change mid-ramp
    mode = 3'b010; custom = 20'h00001;
    run_beats(1, w);
    chk("R10 restart", w, 32'h0);
    run_beats(1, w);
    chk("R10 after restart", w, 32'h0000_1000);

    // R9 decimated strobe select
    idle_mode();
    adv_sel = 1'b1; mode = 3'b110; custom = 20'hF0F0F;
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    chk("R9 sample strobe ignored", {31'b0, out_valid}, 32'h0);
    dec_stb = 1'b1;
    @(negedge clk);
    dec_stb = 1'b0;
    chk("R9 decimated strobe", out_data, 32'hF0F0_F000);
    chk("R9 decimated valid", {31'b0, out_valid}, 32'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule